// File: doc/BRIEF.md
# SDRAM Refresh and Self-Refresh Sequencer

This controller-side block keeps an SDRAM supplied with AUTO REFRESH commands and moves the device into and out of self refresh. A refresh interval timer builds up a count of owed refreshes. In distributed mode one refresh is owed after each equal slice of the refresh period. In burst mode the whole quota becomes owed at the end of each period. While refreshes are owed, the block requests a command slot from the controller's arbiter. The arbiter is expected to close every open bank before it grants the slot. The refresh command goes out in the cycle after the grant, and consecutive refreshes are spaced by the row cycle time.

A sleep request also asks the arbiter for a slot. When that slot is granted, the block issues the refresh command encoding with the clock enable driven low, and the device is then in self refresh. After a minimum residency, and once a wake request and a stable-clock indication are both present, the clock enable rises. The block then holds only NOP commands for max(T_XSR, 2) cycles before it reports ready again. Leaving self refresh restarts the interval timer and clears the refresh debt, because the device has refreshed itself while asleep.

All timing values are parameters counted in clock cycles. The scheduling mode is a static configuration input.

Top module: `sdram_refresh_seq`

## Requirements
- R1: After reset, cke is 1, ready is 1, arb_req is 0 and sd_cmd is NOP. Commands are encoded as {cs_n, ras_n, cas_n, we_n}: NOP = 4'b0111 and REFRESH = 4'b0001.
- R2: In distributed mode (burst_mode = 0), one refresh becomes owed every T_REF/N_REF cycles. When the arbiter grants at once, N_REF refresh commands appear in each T_REF window.
- R3: In burst mode (burst_mode = 1), N_REF refreshes become owed at the end of each T_REF period. No two REFRESH commands are ever closer than T_RC cycles, and a granted burst is issued exactly T_RC cycles apart.
- R4: A REFRESH command appears only in the cycle after a clock edge at which both arb_req and arb_grant were high. Without a grant, arb_req stays high and no command is issued.
- R5: The count of owed refreshes saturates at N_REF. After two periods without a grant in burst mode, only N_REF refreshes are issued.
- R6: sleep_req raises arb_req and takes priority over owed refreshes. In the cycle after the grant, sd_cmd is REFRESH with cke at 0, and ready goes to 0 in that same cycle.
- R7: While in self refresh, cke stays 0, sd_cmd is NOP and arb_req is 0. Counting the entry cycle, cke stays low for at least T_RAS+1 cycles.
- R8: cke rises only after a cycle in which wake_req and clk_stable are both high. Once residency is complete, cke rises in the cycle after the first such cycle.
- R9: From the cycle in which cke rises, sd_cmd is NOP and ready is 0 for exactly max(T_XSR, 2) cycles. After that, ready returns to 1.
- R10: Leaving self refresh restarts the interval timer with no owed refreshes. In distributed mode the first refresh after ready returns comes no sooner than T_REF/N_REF cycles later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| burst_mode | input | 1 | Static scheduling mode: 0 distributed, 1 burst |
| sleep_req | input | 1 | Request to enter self refresh |
| wake_req | input | 1 | Request to leave self refresh |
| clk_stable | input | 1 | Clock is within its timing limits |
| arb_grant | input | 1 | Arbiter grants the requested slot, with all banks idle |
| arb_req | output | 1 | Slot request to the arbiter |
| sd_cmd | output | 4 | SDRAM command {cs_n, ras_n, cas_n, we_n} |
| cke | output | 1 | SDRAM clock enable |
| ready | output | 1 | Normal operation; low from self-refresh entry to the end of the exit window |

## Verification
On every cycle, the assertions check the following:
- each REFRESH command follows a grant, and refreshes keep the T_RC spacing;
- the debt never exceeds N_REF and is never taken below zero;
- self refresh always begins with the REFRESH encoding and stays quiet while cke is low;
- a rising cke follows wake_req together with clk_stable, and is followed by at least two NOP cycles without ready.

The directed scenarios are needed to show the quantities that only appear over whole runs: the number of refreshes per period in each mode, saturation after missed grants, the exact residency and exit-window lengths, and the restart of the timer after wake-up.

// File: rtl/sdrs_pkg.sv
package sdrs_pkg;

    typedef enum logic [1:0] {
        PS_RUN  = 2'd0,
        PS_SELF = 2'd1,
        PS_EXIT = 2'd2
    } pwr_state_e;

    // {cs_n, ras_n, cas_n, we_n}
    localparam logic [3:0] CMD_NOP     = 4'b0111;
    localparam logic [3:0] CMD_REFRESH = 4'b0001;

endpackage

// File: rtl/sdrs_ref_timer.sv
module sdrs_ref_timer #(
    parameter int T_REF = 8000000,
    parameter int N_REF = 8192
) (
    input  logic clk,
    input  logic rst_n,
    input  logic burst_mode,
    input  logic restart,
    input  logic take,
    output logic pending_next
);
    localparam int IVL = T_REF / N_REF;
    localparam int PW  = $clog2(T_REF + 1);
    localparam int IW  = $clog2(IVL + 1);
    localparam int OW  = $clog2(N_REF + 1);

    typedef struct packed {
        logic [PW-1:0] per;
        logic [IW-1:0] ivl;
        logic [OW-1:0] owed;
    } tmr_t;

    tmr_t q, d;
    logic [OW:0] add;
    logic [OW:0] sum;
    logic        per_wrap, ivl_wrap;

    always_comb begin
        d        = q;
        per_wrap = (q.per == PW'(T_REF - 1));
        ivl_wrap = (q.ivl == IW'(IVL - 1));
        d.per    = per_wrap ? '0 : q.per + 1'b1;
        d.ivl    = ivl_wrap ? '0 : q.ivl + 1'b1;
        add      = '0;
        if (burst_mode) begin
            if (per_wrap) add = (OW+1)'(N_REF);
        end else begin
            if (ivl_wrap) add = (OW+1)'(1);
        end
        sum = {1'b0, q.owed} + add - {{OW{1'b0}}, take};
        if (sum > (OW+1)'(N_REF)) sum = (OW+1)'(N_REF);
        d.owed = sum[OW-1:0];
        if (restart) d = '0;
        pending_next = (d.owed != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    a_r5_debt_cap: assert property (@(posedge clk) disable iff (!rst_n)
        q.owed <= OW'(N_REF));
    a_r4_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (q.owed != '0));

endmodule

// File: rtl/sdrs_pwr_fsm.sv
module sdrs_pwr_fsm
    import sdrs_pkg::*;
#(
    parameter int T_RAS   = 6,
    parameter int XSR_CYC = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enter,
    input  logic       wake_req,
    input  logic       clk_stable,
    output pwr_state_e state_o,
    output pwr_state_e state_next_o,
    output logic       exit_done
);
    localparam int MX = (T_RAS > XSR_CYC) ? T_RAS : XSR_CYC;
    localparam int CW = $clog2(MX + 1);

    typedef struct packed {
        pwr_state_e    st;
        logic [CW-1:0] cnt;
    } pwr_t;

    pwr_t q, d;

    always_comb begin
        d         = q;
        exit_done = 1'b0;
        unique case (q.st)
            PS_RUN: begin
                if (enter) begin
                    d.st  = PS_SELF;
                    d.cnt = CW'(T_RAS);
                end
            end
            PS_SELF: begin
                if (q.cnt != '0) begin
                    d.cnt = q.cnt - 1'b1;
                end else if (wake_req && clk_stable) begin
                    d.st  = PS_EXIT;
                    d.cnt = CW'(XSR_CYC - 1);
                end
            end
            PS_EXIT: begin
                if (q.cnt != '0) begin
                    d.cnt = q.cnt - 1'b1;
                end else begin
                    d.st      = PS_RUN;
                    exit_done = 1'b1;
                end
            end
            default: d.st = PS_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: PS_RUN, cnt: '0};
        else        q <= d;
    end

    assign state_o      = q.st;
    assign state_next_o = d.st;

    a_r7_enter_only_from_run: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == PS_SELF && $past(q.st) != PS_SELF) |-> $past(enter));

endmodule

// File: rtl/sdram_refresh_seq.sv
module sdram_refresh_seq
    import sdrs_pkg::*;
#(
    parameter int T_REF = 8000000,
    parameter int N_REF = 8192,
    parameter int T_RC  = 8,
    parameter int T_RAS = 6,
    parameter int T_XSR = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       burst_mode,
    input  logic       sleep_req,
    input  logic       wake_req,
    input  logic       clk_stable,
    input  logic       arb_grant,
    output logic       arb_req,
    output logic [3:0] sd_cmd,
    output logic       cke,
    output logic       ready
);
    localparam int XSR_CYC = (T_XSR < 2) ? 2 : T_XSR;
    localparam int RW      = $clog2(T_RC + 1);

    typedef struct packed {
        logic          req;
        logic          kind;   // 1: sleep slot, 0: refresh slot
        logic [3:0]    cmd;
        logic [RW-1:0] rc;
    } top_t;

    top_t       q, d;
    logic       grant_hit, take, enter, pending_next, exit_done;
    pwr_state_e pst, pst_next;

    sdrs_ref_timer #(.T_REF(T_REF), .N_REF(N_REF)) u_tmr (
        .clk          (clk),
        .rst_n        (rst_n),
        .burst_mode   (burst_mode),
        .restart      (exit_done),
        .take         (take),
        .pending_next (pending_next)
    );

    sdrs_pwr_fsm #(.T_RAS(T_RAS), .XSR_CYC(XSR_CYC)) u_pwr (
        .clk          (clk),
        .rst_n        (rst_n),
        .enter        (enter),
        .wake_req     (wake_req),
        .clk_stable   (clk_stable),
        .state_o      (pst),
        .state_next_o (pst_next),
        .exit_done    (exit_done)
    );

    always_comb begin
        grant_hit = q.req && arb_grant;
        enter     = grant_hit && q.kind;
        take      = grant_hit && !q.kind;
        d         = q;
        d.cmd     = grant_hit ? CMD_REFRESH : CMD_NOP;
        if (grant_hit)        d.rc = RW'(T_RC - 1);
        else if (q.rc != '0)  d.rc = q.rc - 1'b1;
        d.kind = sleep_req;
        d.req  = (pst_next == PS_RUN) && !grant_hit && (d.rc == '0)
                 && (sleep_req || pending_next);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{req: 1'b0, kind: 1'b0, cmd: CMD_NOP, rc: '0};
        else        q <= d;
    end

    assign arb_req = q.req;
    assign sd_cmd  = q.cmd;
    assign cke     = (pst != PS_SELF);
    assign ready   = (pst == PS_RUN);

    // checker-side spacing counter for refresh commands
    logic [RW-1:0] since_ref;
    logic          seen_ref;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_ref <= '0;
            seen_ref  <= 1'b0;
        end else if (sd_cmd == CMD_REFRESH) begin
            since_ref <= RW'(1);
            seen_ref  <= 1'b1;
        end else if (since_ref != RW'(T_RC)) begin
            since_ref <= since_ref + 1'b1;
        end
    end

    a_r3_rc_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_cmd == CMD_REFRESH && seen_ref) |-> (since_ref >= RW'(T_RC)));
    a_r4_cmd_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_cmd == CMD_REFRESH) |-> $past(arb_req && arb_grant));
    a_r6_entry_code: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cke) |-> (sd_cmd == CMD_REFRESH && !ready));
    a_r7_quiet_in_self: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke && $past(!cke)) |-> (sd_cmd == CMD_NOP && !arb_req));
    a_r8_exit_cond: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke) |-> $past(wake_req && clk_stable));
    a_r9_nop_floor: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke) |=> (sd_cmd == CMD_NOP && !ready));

endmodule

// File: tb/sim_sdram_refresh_seq.sv
module sim_sdram_refresh_seq;
    localparam int T_REF = 64;
    localparam int N_REF = 4;
    localparam int T_RC  = 5;
    localparam int T_RAS = 10;
    localparam int T_XSR = 1;
    localparam int IVL   = T_REF / N_REF;
    localparam int XSR_EXP = (T_XSR < 2) ? 2 : T_XSR;
    localparam logic [3:0] NOP = 4'b0111;
    localparam logic [3:0] REF = 4'b0001;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic burst_mode = 1'b0, sleep_req = 1'b0, wake_req = 1'b0, clk_stable = 1'b1;
    logic gnt_en = 1'b0;
    logic arb_grant, arb_req, cke, ready;
    logic [3:0] sd_cmd;

    int checks = 0, fails = 0;
    int cyc = 0, ref_cnt = 0, last_ref = -1, min_gap = 1000000;

    assign arb_grant = gnt_en && arb_req;

    always #4 clk = ~clk;

    sdram_refresh_seq #(.T_REF(T_REF), .N_REF(N_REF), .T_RC(T_RC),
                        .T_RAS(T_RAS), .T_XSR(T_XSR)) u0 (
        .clk(clk), .rst_n(rst_n), .burst_mode(burst_mode),
        .sleep_req(sleep_req), .wake_req(wake_req), .clk_stable(clk_stable),
        .arb_grant(arb_grant), .arb_req(arb_req), .sd_cmd(sd_cmd),
        .cke(cke), .ready(ready));

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (rst_n && sd_cmd == REF && cke) begin
            ref_cnt <= ref_cnt + 1;
            if (last_ref >= 0 && (cyc - last_ref) < min_gap) min_gap <= cyc - last_ref;
            last_ref <= cyc;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset(input logic mode, input logic g);
        rst_n = 1'b0;
        burst_mode = mode;
        gnt_en = g;
        sleep_req = 1'b0; wake_req = 1'b0; clk_stable = 1'b1;
        wait_cyc(3);
        ref_cnt = 0; last_ref = -1; min_gap = 1000000;
        rst_n = 1'b1;
    endtask

    task automatic t_reset;
        do_reset(1'b0, 1'b0);
        @(negedge clk);
        chk(cke == 1'b1, "R1 cke", cke, 1);
        chk(ready == 1'b1, "R1 ready", ready, 1);
        chk(arb_req == 1'b0, "R1 arb_req", arb_req, 0);
        chk(sd_cmd == NOP, "R1 sd_cmd", sd_cmd, NOP);
    endtask

    task automatic t_distributed;
        do_reset(1'b0, 1'b1);
        wait_cyc(4 * T_REF + 10);
        chk(ref_cnt == 4 * N_REF, "R2 refresh count", ref_cnt, 4 * N_REF);
        chk(min_gap >= IVL, "R2 spacing", min_gap, IVL);
    endtask

    task automatic t_burst;
        do_reset(1'b1, 1'b1);
        wait_cyc(T_REF + 30);
        chk(ref_cnt == N_REF, "R3 burst count", ref_cnt, N_REF);
        chk(min_gap == T_RC, "R3 burst gap", min_gap, T_RC);
    endtask

    task automatic t_no_grant_saturate;
        do_reset(1'b1, 1'b0);
        wait_cyc(T_REF + 6);
        chk(arb_req == 1'b1, "R4 req held", arb_req, 1);
        chk(ref_cnt == 0, "R4 no cmd without grant", ref_cnt, 0);
        wait_cyc(T_REF + 6);
        gnt_en = 1'b1;
        wait_cyc(40);
        chk(ref_cnt == N_REF, "R5 saturation", ref_cnt, N_REF);
    endtask

    task automatic t_self_refresh;
        int n;
        int lim;
        do_reset(1'b0, 1'b1);
        sleep_req = 1'b1;
        lim = 0;
        while (cke && lim < 30) begin @(negedge clk); lim++; end
        chk(sd_cmd == REF, "R6 entry cmd", sd_cmd, REF);
        chk(ready == 1'b0, "R6 ready low", ready, 0);
        sleep_req = 1'b0;
        wait_cyc(25);
        chk(cke == 1'b0, "R7 cke low", cke, 0);
        chk(sd_cmd == NOP, "R7 cmd nop", sd_cmd, NOP);
        chk(arb_req == 1'b0, "R7 no req", arb_req, 0);
        clk_stable = 1'b0;
        wake_req = 1'b1;
        wait_cyc(10);
        chk(cke == 1'b0, "R8 waits stable clock", cke, 0);
        clk_stable = 1'b1;
        lim = 0;
        while (!cke && lim < 10) begin @(negedge clk); lim++; end
        chk(lim == 1, "R8 exit latency", lim, 1);
        n = 0;
        while (!ready && n < 20) begin
            if (sd_cmd != NOP) chk(1'b0, "R9 nop in window", sd_cmd, NOP);
            n++;
            @(negedge clk);
        end
        chk(n == XSR_EXP, "R9 window length", n, XSR_EXP);
        wake_req = 1'b0;
        n = 0;
        ref_cnt = 0;
        while (ref_cnt == 0 && n < 40) begin @(negedge clk); n++; end
        chk(n >= IVL && n <= IVL + 3, "R10 timer restart", n, IVL + 1);
    endtask

    task automatic t_residency;
        int n;
        int lim;
        do_reset(1'b0, 1'b1);
        sleep_req = 1'b1; wake_req = 1'b1;
        lim = 0;
        while (cke && lim < 30) begin @(negedge clk); lim++; end
        sleep_req = 1'b0;
        n = 0;
        while (!cke && n < 40) begin @(negedge clk); n++; end
        chk(n == T_RAS + 1, "R7 residency", n, T_RAS + 1);
        wake_req = 1'b0;
        wait_cyc(5);
        chk(ready == 1'b1, "R9 ready back", ready, 1);
    endtask

    initial begin
        t_reset();
        t_distributed();
        t_burst();
        t_no_grant_saturate();
        t_self_refresh();
        t_residency();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #(8 * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule